// File: doc/BRIEF.md
# Fieldbus Macrocycle Timing Monitor

This block keeps the timing and line-health status for a fieldbus master. It runs three programmable timers that count clock ticks (10 ns units at the nominal clock). The first is a free-running macrocycle timer. The second is a one-shot turnaround timer that measures the gap between two frames the master sends. The third is a one-shot silence timer that measures how long the master waits for a response. Each timer has a 32-bit length register and a live count that can be read.

The block also watches three asynchronous pins from the line driver: an active-low watchdog, carrier detect and transmit error. The watchdog sets a sticky flag, and only a dedicated driver reset clears it. The first watchdog activation in a macrocycle and the first transmit error in a macrocycle are stamped with the current macrocycle count. Transmit errors are counted with saturation. The per-macrocycle status is cleared each time the macrocycle wraps. Software reaches the block through a simple register port: a write strobe with address and data, and a combinational read of the addressed register.

Top module: `fbus_timing_monitor`

## Requirements
- R1: Register addresses: 0 macrocycle length, 1 turnaround length, 2 silence length (these three are read/write and reset to 0); 3, 4, 5 live macrocycle, turnaround and silence counts; 6 status; 7 watchdog stamp; 8 transmit-error count; 9 transmit-error stamp. A write occurs when `wr_en_i` is high at a clock edge. Unused addresses read 0.
- R2: With a nonzero length L, the macrocycle count steps 0,1,…,L-1 and then returns to 0. `new_cycle_o` is high exactly during the cycle in which the count is L-1. With L=0 the count holds and no pulse occurs.
- R3: A start strobe loads a one-shot timer count with 0. The count then rises by one per cycle up to its programmed length L and holds there. The expiry output is high for exactly the one cycle in which the count equals L. The turnaround timer uses `turn_start_i`/`turn_exp_o`; the silence timer uses `sil_start_i`/`sil_exp_o`.
- R4: Status bit 0 becomes 1 once `wdg_ni` has been low. It stays 1 after `wdg_ni` returns high, until `drv_rst_i` is applied.
- R5: The asynchronous inputs pass through two-flop synchronizers. A watchdog activation stores the macrocycle count into the watchdog stamp; the stored value is the count two cycles after the pin changes.
- R6: Only the first watchdog activation in a macrocycle is stamped. Later activations in the same macrocycle leave the stamp unchanged.
- R7: The watchdog stamp clears at the start of each new macrocycle.
- R8: Status bit 1 follows the synchronized carrier-detect pin: 1 while there is traffic, 0 when the bus is idle.
- R9: The transmit-error count increments once per rising edge of `txe_i`; a held level counts once. The first error in a macrocycle is stamped with the macrocycle count, two cycles after the pin rises.
- R10: The transmit-error count saturates at its maximum (255 for the default 8-bit width) instead of wrapping.
- R11: The transmit-error count and its stamp clear at the start of each new macrocycle.
- R12: `drv_rst_i` clears the watchdog flag, both stamps and the error count. The core reset `rst_ni` also clears every length and count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous core reset |
| drv_rst_i | input | 1 | Synchronous driver reset strobe |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address for write and read |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the addressed register |
| turn_start_i | input | 1 | Turnaround timer start strobe |
| sil_start_i | input | 1 | Silence timer start strobe |
| wdg_ni | input | 1 | Active-low line-driver watchdog, asynchronous |
| cd_i | input | 1 | Carrier detect, asynchronous |
| txe_i | input | 1 | Transmit error, asynchronous |
| new_cycle_o | output | 1 | New-macrocycle pulse |
| turn_exp_o | output | 1 | Turnaround expiry pulse |
| sil_exp_o | output | 1 | Silence expiry pulse |

## Verification
The hardest states to reach are the ones that depend on where an event falls within a macrocycle. These are the stamp value, the rejection of a second watchdog activation in the same macrocycle, and the clear at the wrap. The bench first aligns itself on `new_cycle_o`, so it knows the position in the cycle. It then reads the live count just as it toggles a pin and predicts the stamp as that count plus the synchronizer delay. To reach saturation, the bench writes a macrocycle length of 0 to stop the wraps, then sends more than 255 error edges without a clear.

// File: rtl/fbm_pkg.sv
package fbm_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    REG_MLEN   = 4'd0,
    REG_TLEN   = 4'd1,
    REG_SLEN   = 4'd2,
    REG_MCNT   = 4'd3,
    REG_TCNT   = 4'd4,
    REG_SCNT   = 4'd5,
    REG_STAT   = 4'd6,
    REG_WDG_TS = 4'd7,
    REG_TXE_N  = 4'd8,
    REG_TXE_TS = 4'd9
  } reg_addr_e;
endpackage

// File: rtl/fbm_sync.sv
module fbm_sync #(
  parameter int             W       = 1,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/fbm_macro.sv
module fbm_macro #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] len_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;
  logic         run;

  assign run    = (len_i != '0);
  // >= covers a length shrunk below the live count
  assign wrap_o = run && (cnt_q >= len_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (wrap_o) cnt_q <= '0;
    else if (run)    cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  p_count_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !wrap_o) |=> (cnt_q == $past(cnt_q) + 1'b1));
  p_wrap_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (cnt_q == '0));
endmodule

// File: rtl/fbm_timer.sv
module fbm_timer #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] len_i,
  output logic [W-1:0] cnt_o,
  output logic         exp_o
);
  logic [W-1:0] cnt_q;
  logic         run_q;

  assign exp_o = run_q && (cnt_q == len_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= '0;
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == len_i) run_q <= 1'b0;
      else                cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;

  p_exp_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exp_o && !start_i) |=> !exp_o);
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !start_i) |=> $stable(cnt_q));
endmodule

// File: rtl/fbm_status.sv
module fbm_status #(
  parameter int CNT_W = 32,
  parameter int TXE_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             drv_rst_i,
  input  logic             new_cycle_i,
  input  logic [CNT_W-1:0] mcnt_i,
  input  logic             wdg_act_i,
  input  logic             txe_i,
  output logic             wdg_flag_o,
  output logic [CNT_W-1:0] wdg_ts_o,
  output logic [TXE_W-1:0] txe_cnt_o,
  output logic [CNT_W-1:0] txe_ts_o
);
  localparam logic [TXE_W-1:0] TXE_MAX = {TXE_W{1'b1}};

  logic             wdg_d_q, txe_d_q;
  logic             wdg_rise, txe_rise, clr;
  logic             wdg_flag_q, wdg_seen_q, txe_seen_q;
  logic [CNT_W-1:0] wdg_ts_q, txe_ts_q;
  logic [TXE_W-1:0] txe_cnt_q;

  assign wdg_rise = wdg_act_i & ~wdg_d_q;
  assign txe_rise = txe_i & ~txe_d_q;
  assign clr      = new_cycle_i | drv_rst_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wdg_d_q <= 1'b0;
      txe_d_q <= 1'b0;
    end else begin
      wdg_d_q <= wdg_act_i;
      txe_d_q <= txe_i;
    end
  end

  // sticky until driver reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        wdg_flag_q <= 1'b0;
    else if (drv_rst_i) wdg_flag_q <= 1'b0;
    else if (wdg_act_i) wdg_flag_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wdg_ts_q   <= '0;
      wdg_seen_q <= 1'b0;
    end else if (clr) begin
      wdg_ts_q   <= '0;
      wdg_seen_q <= 1'b0;
    end else if (wdg_rise && !wdg_seen_q) begin
      wdg_ts_q   <= mcnt_i;
      wdg_seen_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txe_cnt_q  <= '0;
      txe_ts_q   <= '0;
      txe_seen_q <= 1'b0;
    end else if (clr) begin
      txe_cnt_q  <= '0;
      txe_ts_q   <= '0;
      txe_seen_q <= 1'b0;
    end else if (txe_rise) begin
      if (txe_cnt_q != TXE_MAX) txe_cnt_q <= txe_cnt_q + 1'b1;
      if (!txe_seen_q) begin
        txe_ts_q   <= mcnt_i;
        txe_seen_q <= 1'b1;
      end
    end
  end

  assign wdg_flag_o = wdg_flag_q;
  assign wdg_ts_o   = wdg_ts_q;
  assign txe_cnt_o  = txe_cnt_q;
  assign txe_ts_o   = txe_ts_q;

  p_wdg_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdg_flag_q && !drv_rst_i) |=> wdg_flag_q);
  p_ts_once_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdg_seen_q && !clr) |=> $stable(wdg_ts_q));
  p_wdg_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    new_cycle_i |=> (wdg_ts_q == '0));
  p_no_wrap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txe_cnt_q == TXE_MAX && !clr) |=> (txe_cnt_q == TXE_MAX));
  p_txe_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    new_cycle_i |=> (txe_cnt_q == '0 && txe_ts_q == '0));
endmodule

// File: rtl/fbus_timing_monitor.sv
module fbus_timing_monitor
  import fbm_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int TXE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              drv_rst_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  input  logic              turn_start_i,
  input  logic              sil_start_i,
  input  logic              wdg_ni,
  input  logic              cd_i,
  input  logic              txe_i,
  output logic              new_cycle_o,
  output logic              turn_exp_o,
  output logic              sil_exp_o
);
  logic [CNT_W-1:0] mlen_q, tlen_q, slen_q;
  logic [CNT_W-1:0] mcnt, tcnt, scnt, wdg_ts, txe_ts;
  logic [TXE_W-1:0] txe_cnt;
  logic [2:0]       pins_s;
  logic             wdg_flag;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mlen_q <= '0;
      tlen_q <= '0;
      slen_q <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        REG_MLEN: mlen_q <= wdata_i;
        REG_TLEN: tlen_q <= wdata_i;
        REG_SLEN: slen_q <= wdata_i;
        default: ;
      endcase
    end
  end

  // bit0 watchdog (idle high), bit1 carrier, bit2 tx error
  fbm_sync #(.W(3), .RST_VAL(3'b001)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({txe_i, cd_i, wdg_ni}),
    .q_o   (pins_s)
  );

  fbm_macro #(.W(CNT_W)) u_macro (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .len_i (mlen_q),
    .cnt_o (mcnt),
    .wrap_o(new_cycle_o)
  );

  fbm_timer #(.W(CNT_W)) u_turn (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(turn_start_i),
    .len_i  (tlen_q),
    .cnt_o  (tcnt),
    .exp_o  (turn_exp_o)
  );

  fbm_timer #(.W(CNT_W)) u_sil (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(sil_start_i),
    .len_i  (slen_q),
    .cnt_o  (scnt),
    .exp_o  (sil_exp_o)
  );

  fbm_status #(.CNT_W(CNT_W), .TXE_W(TXE_W)) u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .drv_rst_i  (drv_rst_i),
    .new_cycle_i(new_cycle_o),
    .mcnt_i     (mcnt),
    .wdg_act_i  (~pins_s[0]),
    .txe_i      (pins_s[2]),
    .wdg_flag_o (wdg_flag),
    .wdg_ts_o   (wdg_ts),
    .txe_cnt_o  (txe_cnt),
    .txe_ts_o   (txe_ts)
  );

  always_comb begin
    case (addr_i)
      REG_MLEN:   rdata_o = mlen_q;
      REG_TLEN:   rdata_o = tlen_q;
      REG_SLEN:   rdata_o = slen_q;
      REG_MCNT:   rdata_o = mcnt;
      REG_TCNT:   rdata_o = tcnt;
      REG_SCNT:   rdata_o = scnt;
      REG_STAT:   rdata_o = {{(CNT_W-2){1'b0}}, pins_s[1], wdg_flag};
      REG_WDG_TS: rdata_o = wdg_ts;
      REG_TXE_N:  rdata_o = {{(CNT_W-TXE_W){1'b0}}, txe_cnt};
      REG_TXE_TS: rdata_o = txe_ts;
      default:    rdata_o = '0;
    endcase
  end

  p_len_write_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == REG_MLEN) |=> (mlen_q == $past(wdata_i)));
endmodule

// File: tb/tb_fbus_timing_monitor.sv
module tb_fbus_timing_monitor;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        drv_rst_i = 1'b0, wr_en_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic        turn_start_i = 1'b0, sil_start_i = 1'b0;
  logic        wdg_ni = 1'b1, cd_i = 1'b0, txe_i = 1'b0;
  logic        new_cycle_o, turn_exp_o, sil_exp_o;
  int          checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  fbus_timing_monitor dut (
    .clk_i(clk), .rst_ni(rst_ni), .drv_rst_i(drv_rst_i), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .turn_start_i(turn_start_i), .sil_start_i(sil_start_i),
    .wdg_ni(wdg_ni), .cd_i(cd_i), .txe_i(txe_i),
    .new_cycle_o(new_cycle_o), .turn_exp_o(turn_exp_o), .sil_exp_o(sil_exp_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    addr_i = a;
    #0.5;
    v = rdata_o;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic wait_cycle_start();
    @(negedge clk);
    while (!new_cycle_o) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    @(negedge clk);
    for (int a = 0; a < 16; a++) begin
      rd(a[3:0], v);
      chk($sformatf("R12 reset reg %0d", a), v, 0);
    end
    chk("R2 no pulse at reset", {31'd0, new_cycle_o}, 0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(4'd1, 32'd7);
    wr(4'd2, 32'd3);
    wr(4'd11, 32'hDEAD);
    rd(4'd1, v); chk("R1 turnaround length", v, 7);
    rd(4'd2, v); chk("R1 silence length", v, 3);
    rd(4'd11, v); chk("R1 unused address", v, 0);
  endtask

  task automatic t_macro();
    logic [31:0] v;
    wr(4'd0, 32'd5);
    wait_cycle_start();
    rd(4'd3, v); chk("R2 count at pulse", v, 4);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      rd(4'd3, v); chk("R2 macro count", v, i);
      chk("R2 pulse position", {31'd0, new_cycle_o}, (i == 4) ? 1 : 0);
    end
  endtask

  task automatic t_timer(input bit turn, input int len);
    logic [31:0] v;
    int exp_cnt;
    @(negedge clk);
    if (turn) turn_start_i = 1'b1; else sil_start_i = 1'b1;
    @(negedge clk);
    turn_start_i = 1'b0; sil_start_i = 1'b0;
    for (int i = 0; i < len + 3; i++) begin
      exp_cnt = (i < len) ? i : len;
      rd(turn ? 4'd4 : 4'd5, v);
      chk("R3 timer count", v, exp_cnt);
      chk("R3 expiry pulse", {31'd0, turn ? turn_exp_o : sil_exp_o}, (i == len) ? 1 : 0);
      @(negedge clk);
    end
  endtask

  task automatic t_watchdog();
    logic [31:0] v, m0;
    wr(4'd0, 32'd200);
    wait_cycle_start();
    repeat (10) @(negedge clk);
    rd(4'd3, m0);
    wdg_ni = 1'b0;
    repeat (4) @(negedge clk);
    rd(4'd7, v); chk("R5 watchdog stamp", v, m0 + 2);
    rd(4'd6, v); chk("R4 watchdog flag set", v & 1, 1);
    wdg_ni = 1'b1;
    repeat (4) @(negedge clk);
    rd(4'd6, v); chk("R4 flag sticky after release", v & 1, 1);
    wdg_ni = 1'b0;
    repeat (4) @(negedge clk);
    wdg_ni = 1'b1;
    repeat (4) @(negedge clk);
    rd(4'd7, v); chk("R6 second activation ignored", v, m0 + 2);
    wait_cycle_start();
    @(negedge clk);
    rd(4'd7, v); chk("R7 stamp cleared at new cycle", v, 0);
    rd(4'd6, v); chk("R4 flag survives new cycle", v & 1, 1);
    drv_rst_i = 1'b1;
    @(negedge clk);
    drv_rst_i = 1'b0;
    rd(4'd6, v); chk("R12 driver reset clears flag", v & 1, 0);
  endtask

  task automatic t_carrier();
    logic [31:0] v;
    cd_i = 1'b1;
    repeat (3) @(negedge clk);
    rd(4'd6, v); chk("R8 carrier present", (v >> 1) & 1, 1);
    cd_i = 1'b0;
    repeat (3) @(negedge clk);
    rd(4'd6, v); chk("R8 carrier idle", (v >> 1) & 1, 0);
  endtask

  task automatic t_txerr();
    logic [31:0] v, m0;
    wait_cycle_start();
    repeat (5) @(negedge clk);
    rd(4'd3, m0);
    txe_i = 1'b1;
    repeat (3) @(negedge clk);
    txe_i = 1'b0;
    repeat (3) @(negedge clk);
    rd(4'd8, v); chk("R9 held level counts once", v, 1);
    rd(4'd9, v); chk("R9 error stamp", v, m0 + 2);
    txe_i = 1'b1;
    repeat (3) @(negedge clk);
    txe_i = 1'b0;
    repeat (3) @(negedge clk);
    rd(4'd8, v); chk("R9 second error", v, 2);
    rd(4'd9, v); chk("R9 stamp keeps first", v, m0 + 2);
    wait_cycle_start();
    @(negedge clk);
    rd(4'd8, v); chk("R11 count cleared", v, 0);
    rd(4'd9, v); chk("R11 stamp cleared", v, 0);
  endtask

  task automatic t_saturate();
    logic [31:0] v;
    wr(4'd0, 32'd0);
    for (int i = 0; i < 260; i++) begin
      txe_i = 1'b1; repeat (2) @(negedge clk);
      txe_i = 1'b0; repeat (2) @(negedge clk);
    end
    repeat (3) @(negedge clk);
    rd(4'd8, v); chk("R10 saturated count", v, 255);
    chk("R2 no pulse with zero length", {31'd0, new_cycle_o}, 0);
    drv_rst_i = 1'b1;
    @(negedge clk);
    drv_rst_i = 1'b0;
    rd(4'd8, v); chk("R12 driver reset clears count", v, 0);
  endtask

  task automatic t_core_reset();
    logic [31:0] v;
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    rd(4'd1, v); chk("R12 core reset clears length", v, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog timeout actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_regs();
    t_macro();
    t_timer(1'b1, 7);
    t_timer(1'b0, 3);
    t_watchdog();
    t_carrier();
    t_txerr();
    t_saturate();
    t_core_reset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule